// File: doc/BRIEF.md
# Panel Column to Display RAM Address Mapper

This block turns a panel column index and a line selector into the display RAM address that holds the character shown there, taking the current horizontal scroll into account. The refresh logic presents a column and a line and reads the address back in the same cycle. A scroll offset register follows scroll-left and scroll-right commands. A return-home command clears it, and so does a change of line mode.

In single-line mode the whole display RAM is one ring of 2^ADDR_W entries. In dual-line mode each line owns half the RAM as a ring of its own. The first line uses the lower half and the second line uses the upper half. A scroll wraps each half within itself, so the two lines never spill into each other. The line mode input is registered, and the mapping uses the registered mode.

Top module: `disp_pos_mapper`

## Requirements
- R1: After reset the mode is single-line and the offset is 0, so column c maps to address c and `line_o` is 0.
- R2: In single-line mode `addr_o` = (col_i + offset) mod 128 and `line_o` = 0. `line_i` has no effect.
- R3: In dual-line mode `addr_o` = 64*line_i + ((col_i[5:0] + offset) mod 64) and `line_o` = `line_i`. Bit 6 of `col_i` has no effect.
- R4: A cycle with `shl_i`=1 and `shr_i`=0 adds 1 to the offset, modulo the line length. A cycle with `shr_i`=1 and `shl_i`=0 subtracts 1. After one scroll right from offset 0, column 0 reads 0x7F in single-line mode, and reads 0x3F (line 0) or 0x7F (line 1) in dual-line mode.
- R5: When `shl_i` and `shr_i` are both 1 in the same cycle, the offset does not change.
- R6: `home_i` clears the offset to 0 at the next clock edge and takes priority over scroll commands.
- R7: When `two_line_i` differs from the registered mode, the next edge loads the new mode and clears the offset to 0. This takes priority over home and scroll commands.
- R8: In dual-line mode the offset stays below 64. A scroll left from offset 63 returns it to 0, so after address 0x3F the next address is 0x00 and not 0x40.
- R9: `addr_o` and `line_o` follow `col_i` and `line_i` combinationally, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| two_line_i | input | 1 | Requested mode: 1 = dual-line, 0 = single-line |
| shl_i | input | 1 | Scroll left by one column |
| shr_i | input | 1 | Scroll right by one column |
| home_i | input | 1 | Clear the scroll offset |
| col_i | input | ADDR_W | Panel column index, counted from 0 |
| line_i | input | 1 | Requested line (dual-line mode only) |
| addr_o | output | ADDR_W | Display RAM address for the requested column |
| line_o | output | 1 | Line that the address belongs to |

## Verification
Two pairs of functions can meet in one cycle. The first pair is the combinational lookup and a pending offset update: the lookup must still use the old offset until the edge. The second pair is a mode change arriving together with a home or scroll command, where the mode change must win. The random stimulus raises the mode toggle, home and both scroll lines independently, so all of these meet often. Each case is judged by reading addresses at the ports one cycle later and comparing them with a reference model of offset and mode. Directed steps also drive both scroll lines together, and scroll left across the dual-line window edge.

// File: rtl/disp_map_pkg.sv
package disp_map_pkg;
   typedef enum logic [1:0] {
      SCR_HOLD  = 2'b00,
      SCR_LEFT  = 2'b01,
      SCR_RIGHT = 2'b10,
      SCR_CLEAR = 2'b11
   } scroll_op_e;

   function automatic scroll_op_e decode_op(input logic home, input logic left, input logic right);
      if (home)               return SCR_CLEAR;
      else if (left && !right) return SCR_LEFT;
      else if (right && !left) return SCR_RIGHT;
      else                     return SCR_HOLD;
   endfunction
endpackage

// File: rtl/dm_offset_reg.sv
module dm_offset_reg
   import disp_map_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_req_i,
   input  logic              home_i,
   input  logic              shl_i,
   input  logic              shr_i,
   output logic              mode_o,
   output logic [ADDR_W-1:0] off_o
);
   localparam int WIN_W = ADDR_W - 1;

   logic              mode_q;
   logic [ADDR_W-1:0] off_q;
   logic [ADDR_W-1:0] off_d;
   logic [ADDR_W-1:0] len_mask;
   scroll_op_e        op;

   assign len_mask = mode_q ? {1'b0, {WIN_W{1'b1}}} : {ADDR_W{1'b1}};
   assign op       = decode_op(home_i, shl_i, shr_i);

   always_comb begin
      unique case (op)
         SCR_LEFT:  off_d = (off_q + 1'b1) & len_mask;
         SCR_RIGHT: off_d = (off_q - 1'b1) & len_mask;
         SCR_CLEAR: off_d = '0;
         default:   off_d = off_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         off_q  <= '0;
      end else if (mode_req_i != mode_q) begin
         mode_q <= mode_req_i;
         off_q  <= '0;
      end else begin
         off_q  <= off_d;
      end
   end

   assign mode_o = mode_q;
   assign off_o  = off_q;
endmodule

// File: rtl/dm_ring_map.sv
module dm_ring_map #(
   parameter int RING_W = 7,
   parameter int ADDR_W = 7
) (
   input  logic [RING_W-1:0] col_i,
   input  logic [RING_W-1:0] off_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [RING_W-1:0] slot;

   generate
      if (RING_W > ADDR_W) begin : g_bad_width
         $error("dm_ring_map: RING_W exceeds ADDR_W");
      end
   endgenerate

   assign slot   = col_i + off_i;
   assign addr_o = base_i + ADDR_W'(slot);
endmodule

// File: rtl/disp_pos_mapper.sv
module disp_pos_mapper #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              two_line_i,
   input  logic              shl_i,
   input  logic              shr_i,
   input  logic              home_i,
   input  logic [ADDR_W-1:0] col_i,
   input  logic              line_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              line_o
);
   localparam int WIN_W  = ADDR_W - 1;
   localparam int NLINES = 2;

   generate
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_param
         $error("disp_pos_mapper: ADDR_W must be within 2..16");
      end
   endgenerate

   logic              mode_q;
   logic [ADDR_W-1:0] off_q;
   logic [ADDR_W-1:0] ring_addr;
   logic [ADDR_W-1:0] win_addr [NLINES];

   dm_offset_reg #(.ADDR_W(ADDR_W)) u_off (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_req_i (two_line_i),
      .home_i     (home_i),
      .shl_i      (shl_i),
      .shr_i      (shr_i),
      .mode_o     (mode_q),
      .off_o      (off_q)
   );

   dm_ring_map #(.RING_W(ADDR_W), .ADDR_W(ADDR_W)) u_ring (
      .col_i  (col_i),
      .off_i  (off_q),
      .base_i ({ADDR_W{1'b0}}),
      .addr_o (ring_addr)
   );

   generate
      for (genvar g = 0; g < NLINES; g++) begin : g_win
         dm_ring_map #(.RING_W(WIN_W), .ADDR_W(ADDR_W)) u_win (
            .col_i  (col_i[WIN_W-1:0]),
            .off_i  (off_q[WIN_W-1:0]),
            .base_i (ADDR_W'(g) << WIN_W),
            .addr_o (win_addr[g])
         );
      end
   endgenerate

   always_comb begin
      if (mode_q) begin
         addr_o = win_addr[line_i];
         line_o = line_i;
      end else begin
         addr_o = ring_addr;
         line_o = 1'b0;
      end
   end
endmodule

// File: rtl/disp_pos_mapper_chk.sv
module disp_pos_mapper_chk #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              two_line_i,
   input logic              shl_i,
   input logic              shr_i,
   input logic              home_i,
   input logic              line_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic              line_o,
   input logic              mode_q,
   input logic [ADDR_W-1:0] off_q
);
   logic [ADDR_W-1:0] msk;
   logic              same_mode;
   assign msk       = mode_q ? {1'b0, {(ADDR_W-1){1'b1}}} : {ADDR_W{1'b1}};
   assign same_mode = (two_line_i == mode_q);

   a_r2_single_line: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> (line_o == 1'b0));

   a_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |-> (addr_o[ADDR_W-1] == line_i && line_o == line_i));

   a_r4_left: assert property (@(posedge clk) disable iff (!rst_n)
      (same_mode && !home_i && shl_i && !shr_i) |=>
      (off_q == ((ADDR_W'($past(off_q) + 1'b1)) & msk)));

   a_r4_right: assert property (@(posedge clk) disable iff (!rst_n)
      (same_mode && !home_i && shr_i && !shl_i) |=>
      (off_q == ((ADDR_W'($past(off_q) - 1'b1)) & msk)));

   a_r5_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (same_mode && !home_i && shl_i && shr_i) |=> $stable(off_q));

   a_r6_home: assert property (@(posedge clk) disable iff (!rst_n)
      (same_mode && home_i) |=> (off_q == '0));

   a_r7_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
      !same_mode |=> (off_q == '0 && mode_q == $past(two_line_i)));

   a_r8_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |-> !off_q[ADDR_W-1]);
endmodule

bind disp_pos_mapper disp_pos_mapper_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .two_line_i (two_line_i),
   .shl_i      (shl_i),
   .shr_i      (shr_i),
   .home_i     (home_i),
   .line_i     (line_i),
   .addr_o     (addr_o),
   .line_o     (line_o),
   .mode_q     (mode_q),
   .off_q      (off_q)
);

// File: tb/disp_pos_mapper_test.sv
module disp_pos_mapper_test;
   localparam int AW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          two_line_i = 1'b0;
   logic          shl_i = 1'b0;
   logic          shr_i = 1'b0;
   logic          home_i = 1'b0;
   logic [AW-1:0] col_i = '0;
   logic          line_i = 1'b0;
   logic [AW-1:0] addr_o;
   logic          line_o;

   int checks = 0;
   int errors = 0;
   logic          m_mode = 1'b0;
   logic [AW-1:0] m_off = '0;

   always #4 clk = ~clk;

   disp_pos_mapper #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .two_line_i(two_line_i), .shl_i(shl_i),
      .shr_i(shr_i), .home_i(home_i), .col_i(col_i), .line_i(line_i),
      .addr_o(addr_o), .line_o(line_o)
   );

   function automatic logic [AW-1:0] exp_addr(input logic mode, input logic [AW-1:0] off,
                                              input logic [AW-1:0] col, input logic ln);
      logic [AW-1:0] s;
      s = col + off;
      if (mode) return {ln, s[AW-2:0]};
      return s;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_map(input string req);
      check(req, int'(addr_o), int'(exp_addr(m_mode, m_off, col_i, line_i)));
      check(req, int'(line_o), int'(m_mode ? line_i : 1'b0));
   endtask

   task automatic model_edge();
      logic [AW-1:0] msk;
      msk = m_mode ? {1'b0, {(AW-1){1'b1}}} : {AW{1'b1}};
      if (two_line_i != m_mode) begin
         m_mode = two_line_i;
         m_off  = '0;
      end else if (home_i) m_off = '0;
      else if (shl_i && !shr_i) m_off = (m_off + 1'b1) & msk;
      else if (shr_i && !shl_i) m_off = (m_off - 1'b1) & msk;
   endtask

   task automatic step(input logic tl, input logic h, input logic l, input logic r);
      @(negedge clk);
      two_line_i = tl; home_i = h; shl_i = l; shr_i = r;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      two_line_i = tl; home_i = 1'b0; shl_i = 1'b0; shr_i = 1'b0;
   endtask

   task automatic probe(input logic [AW-1:0] c, input logic ln, input int exp, input string req);
      col_i = c; line_i = ln;
      #1;
      check(req, int'(addr_o), exp);
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      probe(7'd0, 1'b0, 'h00, "R1");
      probe(7'd127, 1'b1, 'h7F, "R1");
      check("R1", int'(line_o), 0);
      // R4 left shift in single-line mode
      step(1'b0, 1'b0, 1'b1, 1'b0);
      probe(7'd0, 1'b0, 'h01, "R4");
      probe(7'd127, 1'b0, 'h00, "R2");
      // R4 right wrap
      step(1'b0, 1'b0, 1'b0, 1'b1);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      probe(7'd0, 1'b0, 'h7F, "R4");
      // R5 both scroll lines
      step(1'b0, 1'b0, 1'b1, 1'b1);
      probe(7'd0, 1'b0, 'h7F, "R5");
      // R6 home beats scroll
      step(1'b0, 1'b1, 1'b1, 1'b0);
      probe(7'd5, 1'b0, 'h05, "R6");
      // R7 mode change with scroll pending
      step(1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b1, 1'b0, 1'b1, 1'b0);
      probe(7'd0, 1'b1, 'h40, "R7");
      check("R7", int'(line_o), 1);
      // R3 bit 6 of column ignored
      probe(7'h45, 1'b0, 'h05, "R3");
      // R4 right in dual-line
      step(1'b1, 1'b0, 1'b0, 1'b1);
      probe(7'd0, 1'b0, 'h3F, "R4");
      probe(7'd0, 1'b1, 'h7F, "R4");
      // R8 left wrap inside window
      step(1'b1, 1'b1, 1'b0, 1'b0);
      probe(7'd63, 1'b0, 'h3F, "R8");
      step(1'b1, 1'b0, 1'b1, 1'b0);
      probe(7'd63, 1'b0, 'h00, "R8");
      // R9 combinational lookup, no edge needed
      col_i = 7'd10; line_i = 1'b1; #1;
      check("R9", int'(addr_o), 'h4B);
      col_i = 7'd20; #1;
      check("R9", int'(addr_o), 'h55);
      // random mix
      void'($urandom(32'd1357));
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         two_line_i = ($urandom % 16 == 0) ? ~two_line_i : two_line_i;
         home_i     = ($urandom % 10 == 0);
         shl_i      = ($urandom % 3 == 0);
         shr_i      = ($urandom % 3 == 0);
         col_i      = AW'($urandom);
         line_i     = 1'($urandom);
         #1;
         check_map(m_mode ? "R3" : "R2");
         @(posedge clk);
         model_edge();
      end
      @(negedge clk);
      home_i = 1'b0; shl_i = 1'b0; shr_i = 1'b0;
      #1;
      check_map("R7");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule